// File: doc/BRIEF.md
# Line Latch and Output Mode Sequencer

This block sits between the column data register of a display source driver and its analog output stage. Once per display line a strobe arrives. On the first clock edge that sees the strobe high, the whole row of gray-level codes is copied into an output latch, and the polarity input is captured with it. The codes stay frozen for the rest of the line. The block also decides, cycle by cycle, what every column output does: shorted to a common reset level, left floating (high impedance), or driving its gray level. From the captured polarity it gives each column a bank select, which picks the upper or the lower reference bank.

The mode input picks one of two output sequences for a line. The mode value is taken at the strobe's first high sample. In the shorting sequence, the outputs stay in reset for as long as the strobe is high, and drive begins when the strobe drops. In the floating sequence, the outputs go high impedance for a fixed number of clocks after the strobe sample, and drive then begins whatever the strobe is doing. The block also watches the strobe. It flags a strobe whose high width is out of range, and it flags any change on the data-inversion input while the strobe is high, because that change would put the column logic into its test mode.

Top module: `line_out_seq`

## Requirements
- R1: On a clock edge where `stb` is sampled high after being sampled low (a line start), `lat_codes` takes the value of `reg_codes` and shows it after that edge. Column c occupies bits [c*6 +: 6].
- R2: Between line starts, `lat_codes` keeps its value whatever `reg_codes` does.
- R3: For a line started with `mode`=1, `out_state` is 2'b00 (reset) from the line start through every edge at which `stb` is still sampled high.
- R4: For a line started with `mode`=1, `out_state` becomes 2'b10 (drive) at the first edge that samples `stb` low, and stays there until the next line start.
- R5: For a line started with `mode`=0, `out_state` is 2'b01 (high impedance) after the line-start edge and after the next edge. It becomes 2'b10 after the second edge following the line start, whether `stb` is high or low at that point.
- R6: `mode` is used only at the line-start edge. Changes to it later in the line do not alter the sequence.
- R7: `pol` is captured at the line-start edge only. `bank_sel[c]` (1 = upper bank) equals the inverse of the captured polarity for even c and the captured polarity for odd c. Even c means odd-numbered output c+1.
- R8: At the first edge that samples `stb` low after a high run, `width_err` pulses high for exactly one cycle if the number of high samples in that run was below 3 or above 111. It stays low otherwise.
- R9: `inv_err` pulses high for one cycle after an edge where `stb` was sampled high at both that edge and the previous edge and `inv` differs between those two samples. A change of `inv` while `stb` is low never raises it.
- R10: While `rst_n` is low, `out_state` is 2'b01, `lat_codes` is all zero, the captured polarity is 0, and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stb | input | 1 | Line strobe, high for 3 to 111 clocks once per line |
| mode | input | 1 | Output sequence select: 1 shorting, 0 floating |
| pol | input | 1 | Line polarity for the bank assignment |
| inv | input | 1 | Data-inversion level, monitored for changes during the strobe |
| reg_codes | input | NUM_COL*CODE_W | Row of gray codes from the data register |
| lat_codes | output | NUM_COL*CODE_W | Latched row of gray codes for the converters |
| out_state | output | 2 | Output state shared by all columns: 00 reset, 01 high-Z, 10 drive |
| bank_sel | output | NUM_COL | Per-column reference bank, 1 upper, 0 lower |
| width_err | output | 1 | One-cycle pulse for a strobe width outside 3..111 |
| inv_err | output | 1 | One-cycle pulse for an inversion change while the strobe is high |

## Verification
The bench targets the edges of the floating sequence. It uses a three-clock strobe, so drive must start while the strobe is still high. A sequencer that waited for the strobe's fall, or that counted one edge too few, would show drive too late or too early. The bench also scrambles `reg_codes`, `mode` and `pol` in every high cycle of a line. A latch that stays transparent, or a sequencer that reads mode live instead of at line start, would then show changed codes, a swapped bank pattern or a sequence that jumps between reset and high impedance. Strobe widths of 2, 3, 111 and 112 probe both limits of the width check, where an off-by-one counter would flag a legal width or miss an illegal one. Inversion toggles placed both inside and outside the strobe separate a real error from a false alarm.

// File: rtl/line_out_seq_pkg.sv
package line_out_seq_pkg;

  typedef enum logic [1:0] {
    OST_RESET = 2'b00,
    OST_HIZ   = 2'b01,
    OST_DRIVE = 2'b10
  } ost_e;

  // Upper-bank select for zero-based column col under captured polarity pl.
  function automatic logic upper_bank(input int col, input logic pl);
    return ((col % 2) == 0) ? ~pl : pl;
  endfunction

  // Strobe high-run length check.
  function automatic logic width_legal(input int w, input int lo, input int hi);
    return (w >= lo) && (w <= hi);
  endfunction

endpackage

// File: rtl/line_strobe_mon.sv
module line_strobe_mon #(
  parameter int STB_MIN = 3,
  parameter int STB_MAX = 111
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic inv,
  output logic line_rise,
  output logic line_fall,
  output logic width_err,
  output logic inv_err
);
  import line_out_seq_pkg::*;

  localparam int CNT_SAT = STB_MAX + 1;
  localparam int HW      = $clog2(CNT_SAT + 1);

  logic          stb_q;
  logic          inv_q;
  logic [HW-1:0] hcnt;
  logic          held_high;

  assign line_rise = stb & ~stb_q;
  assign line_fall = ~stb & stb_q;
  assign held_high = stb & stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q     <= 1'b0;
      inv_q     <= 1'b0;
      hcnt      <= '0;
      width_err <= 1'b0;
      inv_err   <= 1'b0;
    end else begin
      stb_q     <= stb;
      inv_q     <= inv;
      width_err <= 1'b0;
      inv_err   <= held_high & (inv ^ inv_q);
      if (line_rise) begin
        hcnt <= HW'(1);
      end else if (held_high) begin
        if (hcnt != HW'(CNT_SAT)) hcnt <= hcnt + HW'(1);
      end else if (line_fall) begin
        width_err <= ~width_legal(int'(hcnt), STB_MIN, STB_MAX);
      end
    end
  end

endmodule

// File: rtl/line_code_latch.sv
module line_code_latch #(
  parameter int NUM_COL = 384,
  parameter int CODE_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      line_rise,
  input  logic                      pol,
  input  logic [NUM_COL*CODE_W-1:0] reg_codes,
  output logic [NUM_COL*CODE_W-1:0] lat_codes,
  output logic [NUM_COL-1:0]        bank_sel
);
  import line_out_seq_pkg::*;

  logic pol_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_codes <= '0;
      pol_l     <= 1'b0;
    end else if (line_rise) begin
      lat_codes <= reg_codes;
      pol_l     <= pol;
    end
  end

  for (genvar c = 0; c < NUM_COL; c++) begin : g_bank
    assign bank_sel[c] = upper_bank(c, pol_l);
  end

endmodule

// File: rtl/line_out_fsm.sv
module line_out_fsm #(
  parameter int HIZ_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_rise,
  input  logic       line_fall,
  input  logic       mode,
  output logic [1:0] out_state
);
  import line_out_seq_pkg::*;

  localparam int CW = (HIZ_CLKS > 1) ? $clog2(HIZ_CLKS) : 1;

  ost_e          st;
  logic          hiz_pend;
  logic [CW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= OST_HIZ;
      hiz_pend <= 1'b0;
      hcnt     <= '0;
    end else if (line_rise) begin
      st       <= mode ? OST_RESET : OST_HIZ;
      hiz_pend <= ~mode;
      hcnt     <= CW'(HIZ_CLKS - 1);
    end else begin
      unique case (st)
        OST_RESET: if (line_fall) st <= OST_DRIVE;
        OST_HIZ: begin
          if (hiz_pend) begin
            if (hcnt == '0) begin
              st       <= OST_DRIVE;
              hiz_pend <= 1'b0;
            end else begin
              hcnt <= hcnt - CW'(1);
            end
          end
        end
        default: st <= st;
      endcase
    end
  end

  assign out_state = st;

endmodule

// File: rtl/line_out_seq.sv
module line_out_seq #(
  parameter int NUM_COL  = 384,
  parameter int CODE_W   = 6,
  parameter int STB_MIN  = 3,
  parameter int STB_MAX  = 111,
  parameter int HIZ_CLKS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stb,
  input  logic                      mode,
  input  logic                      pol,
  input  logic                      inv,
  input  logic [NUM_COL*CODE_W-1:0] reg_codes,
  output logic [NUM_COL*CODE_W-1:0] lat_codes,
  output logic [1:0]                out_state,
  output logic [NUM_COL-1:0]        bank_sel,
  output logic                      width_err,
  output logic                      inv_err
);

  logic line_rise;
  logic line_fall;

  line_strobe_mon #(.STB_MIN(STB_MIN), .STB_MAX(STB_MAX)) u_mon (
    .clk(clk), .rst_n(rst_n), .stb(stb), .inv(inv),
    .line_rise(line_rise), .line_fall(line_fall),
    .width_err(width_err), .inv_err(inv_err)
  );

  line_code_latch #(.NUM_COL(NUM_COL), .CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .line_rise(line_rise), .pol(pol),
    .reg_codes(reg_codes), .lat_codes(lat_codes), .bank_sel(bank_sel)
  );

  line_out_fsm #(.HIZ_CLKS(HIZ_CLKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .line_rise(line_rise), .line_fall(line_fall),
    .mode(mode), .out_state(out_state)
  );

endmodule

// File: rtl/line_out_seq_chk.sv
module line_out_seq_chk #(
  parameter int NUM_COL = 384,
  parameter int CODE_W  = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      stb,
  input logic                      mode,
  input logic                      pol,
  input logic [NUM_COL*CODE_W-1:0] reg_codes,
  input logic [NUM_COL*CODE_W-1:0] lat_codes,
  input logic [1:0]                out_state,
  input logic [NUM_COL-1:0]        bank_sel,
  input logic                      width_err,
  input logic                      inv_err,
  input logic                      line_rise,
  input logic                      line_fall
);

  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    line_rise |=> lat_codes == $past(reg_codes)); // R1
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_rise |=> $stable(lat_codes)); // R2
  AST_RESET_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rise && mode) |=> out_state == 2'b00); // R3
  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (line_fall && out_state == 2'b00) |=> out_state == 2'b10); // R4
  AST_HIZ_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rise && !mode) |=> out_state == 2'b01); // R5
  AST_BANK_FROM_POL: assert property (@(posedge clk) disable iff (!rst_n)
    line_rise |=> bank_sel[0] == !$past(pol)); // R7
  AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_rise |=> $stable(bank_sel)); // R7
  AST_WIDTH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    width_err |=> !width_err); // R8
  AST_WIDTH_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    width_err |-> $past(line_fall)); // R8
  AST_INV_IN_STB: assert property (@(posedge clk) disable iff (!rst_n)
    inv_err |-> $past(stb)); // R9

endmodule

bind line_out_seq line_out_seq_chk #(.NUM_COL(NUM_COL), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb(stb), .mode(mode), .pol(pol),
  .reg_codes(reg_codes), .lat_codes(lat_codes), .out_state(out_state),
  .bank_sel(bank_sel), .width_err(width_err), .inv_err(inv_err),
  .line_rise(line_rise), .line_fall(line_fall)
);

// File: tb/line_out_seq_tb.sv
`timescale 1ns/1ps
module line_out_seq_tb;
  localparam int NC = 384;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0, mode = 1'b1, pol = 1'b0, inv = 1'b0;
  logic [NC*CW-1:0] reg_codes = '0;
  logic [NC*CW-1:0] lat_codes;
  logic [1:0] out_state;
  logic [NC-1:0] bank_sel;
  logic width_err, inv_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  line_out_seq u_dut (
    .clk(clk), .rst_n(rst_n), .stb(stb), .mode(mode), .pol(pol), .inv(inv),
    .reg_codes(reg_codes), .lat_codes(lat_codes), .out_state(out_state),
    .bank_sel(bank_sel), .width_err(width_err), .inv_err(inv_err)
  );

  // Expected bank pattern: output number c+1 odd -> upper when polarity low.
  function automatic logic [NC-1:0] exp_bank(input logic p);
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = (((c + 1) & 1) == 1) ? !p : p;
    return v;
  endfunction

  function automatic logic exp_werr(input int w);
    return (w < 3) || (w > 111);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_codes(input string tag, input logic [NC*CW-1:0] exp);
    int bad = -1;
    for (int c = 0; c < NC; c++)
      if (bad < 0 && lat_codes[c*CW +: CW] !== exp[c*CW +: CW]) bad = c;
    if (bad < 0) chk(tag, 0, 0);
    else chk(tag, 32'(lat_codes[bad*CW +: CW]), 32'(exp[bad*CW +: CW]));
  endtask

  task automatic chk_bank(input string tag, input logic p);
    logic [NC-1:0] e = exp_bank(p);
    checks++;
    if (bank_sel !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, bank_sel, e);
    end
  endtask

  task automatic rand_codes();
    for (int c = 0; c < NC; c++) reg_codes[c*CW +: CW] = CW'($urandom);
  endtask

  // One line: strobe high for w samples, then gap low cycles.
  task automatic run_line(input int w, input logic m, input logic p, input int inv_at, input int gap);
    logic [NC*CW-1:0] dsave;
    logic [1:0] est;
    @(negedge clk);
    stb = 1'b1; mode = m; pol = p;
    rand_codes();
    dsave = reg_codes;
    for (int i = 0; i < w; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 0) chk_codes("R1 latch copy", dsave);
      else        chk_codes("R2 latch hold", dsave);
      if (m) est = 2'b00;
      else   est = (i >= 2) ? 2'b10 : 2'b01;
      chk(m ? "R3 reset phase" : "R5 hiz/drive phase", 32'(out_state), 32'(est));
      if (i == 0 || i == w - 1) chk_bank("R7 bank select", p);
      chk("R9 inv flag in strobe", 32'(inv_err), 32'(inv_at >= 0 && i == inv_at + 1));
      chk("R8 no early width flag", 32'(width_err), 0);
      rand_codes();
      mode = ~mode;  // R6: mid-line mode change ignored
      pol  = ~pol;
      if (i == inv_at) inv = ~inv;
      if (i == w - 1) stb = 1'b0;
    end
    @(posedge clk); @(negedge clk);
    chk(m ? "R4 drive on fall" : "R5 drive held", 32'(out_state), 32'(2'b10));
    chk("R8 width flag", 32'(width_err), 32'(exp_werr(w)));
    chk("R6 mode ignored mid-line", 32'(out_state), 32'(2'b10));
    chk_codes("R2 latch hold after fall", dsave);
    chk_bank("R7 pol ignored mid-line", p);
    for (int g = 0; g < gap; g++) begin
      if (g == 0) inv = ~inv;
      @(posedge clk); @(negedge clk);
      chk("R4 drive during gap", 32'(out_state), 32'(2'b10));
      chk("R8 flag one cycle", 32'(width_err), 0);
      chk("R9 no flag outside strobe", 32'(inv_err), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset state", 32'(out_state), 32'(2'b01));
    chk_codes("R10 reset latch", '0);
    chk_bank("R10 reset polarity", 1'b0);
    chk("R10 reset width flag", 32'(width_err), 0);
    chk("R10 reset inv flag", 32'(inv_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_line(3,   1'b1, 1'b0, -1, 3);
    run_line(3,   1'b0, 1'b1,  0, 3);
    run_line(111, 1'b0, 1'b0, 50, 2);
    run_line(112, 1'b1, 1'b1, -1, 2);
    run_line(2,   1'b1, 1'b0, -1, 2);
    run_line(4,   1'b0, 1'b1,  2, 2);
    for (int k = 0; k < 24; k++) begin
      int w = 3 + int'($urandom % 18);
      int ia = (($urandom % 3) == 0) ? -1 : int'($urandom % (w - 1));
      run_line(w, 1'($urandom), 1'($urandom), ia, 1 + int'($urandom % 4));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule